// File: doc/BRIEF.md
# Multi-Thread Decode Stage Control Machine

This block holds the control state of one pipeline stage shared by several hardware threads. Each thread owns a five-state status register (Idle, Running, Blocked, Unblocking, Squashing) and three sticky stall flags. There is one stall flag for each downstream consumer: the rename, execute and commit stages. On every clock the block samples the block, unblock and squash strobes. It then selects each thread's next status and emits one-cycle block and unblock notices to the fetch stage upstream.

The instruction storage and decode datapath stay outside the block. The datapath reports three things per thread as level inputs: whether its skid storage is empty, whether instructions remain after the issue slots were used, and whether it found a mispredicted target and wants a redirect. A stage-wide activity flag tells the surrounding pipeline whether any thread is draining skid storage.

All outputs are registered. The inputs sampled at a rising edge take effect on the outputs right after that same edge.

Top module: `dstage_ctrl`

## Requirements
- R1: After a synchronous active-high reset every thread reads Idle and every stall flag is clear. All pulse outputs and the activity flag are low. The per-thread state code is 0 for Idle, 1 for Running, 2 for Blocked, 3 for Unblocking and 4 for Squashing. Thread t occupies bits [3t+2:3t] of `thread_state_o`.
- R2: Each of the three stall flags of a thread is set by its block strobe and cleared by its unblock strobe, and otherwise holds its value. A thread is stalled while any of its flags is set, including a flag set in the current cycle.
- R3: An unblock strobe for a flag that is clear, and that is not being set in the same cycle, raises `stall_err_o` for that thread for one cycle. The flag stays clear.
- R4: Each thread's conditions are judged in a fixed priority: commit squash, then commit still-squashing, then stall, then leaving Blocked, then leaving Squashing, then the datapath requests (redirect, leftover instructions, skid drained).
- R5: A commit squash moves the thread to Squashing. An unblock notice goes upstream only if the thread was Blocked or Unblocking. A stall arriving in the same cycle produces no block notice.
- R6: While commit reports it is still squashing, the thread goes to Squashing and stays there. With no squash and no stall, a Squashing thread moves to Running in one cycle.
- R7: A stalled thread moves to Blocked and sends one block notice, unless it is already Blocked, in which case no further notice is sent.
- R8: A Blocked thread whose stall has cleared moves to Unblocking. Unblocking moves to Running with an unblock notice in the first cycle its skid storage is empty, and otherwise stays in Unblocking.
- R9: An Idle or Running thread with leftover instructions moves to Blocked and sends a block notice. An Idle thread with nothing pending stays Idle.
- R10: A redirect request from an Idle, Running or Unblocking thread moves it to Squashing. An unblock notice goes upstream only if it was Unblocking.
- R11: `stage_active_o` is high exactly when some thread is in Unblocking. It is re-evaluated only in cycles where some thread's status changes.
- R12: For any thread, the block and unblock notices are never high together.
- R13: Threads are independent: one thread's inputs never change another thread's status or notices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rn_blk_i | input | NUM_THREADS | Rename stage block strobe per thread |
| rn_unblk_i | input | NUM_THREADS | Rename stage unblock strobe per thread |
| ex_blk_i | input | NUM_THREADS | Execute stage block strobe per thread |
| ex_unblk_i | input | NUM_THREADS | Execute stage unblock strobe per thread |
| cm_blk_i | input | NUM_THREADS | Commit stage block strobe per thread |
| cm_unblk_i | input | NUM_THREADS | Commit stage unblock strobe per thread |
| cm_squash_i | input | NUM_THREADS | Commit squash per thread |
| cm_busy_i | input | NUM_THREADS | Commit still squashing per thread |
| skid_empty_i | input | NUM_THREADS | Thread's skid storage is empty |
| leftover_i | input | NUM_THREADS | Instructions left after using issue slots |
| redirect_i | input | NUM_THREADS | Datapath requests a redirect squash |
| fetch_block_o | output | NUM_THREADS | One-cycle block notice to fetch |
| fetch_unblock_o | output | NUM_THREADS | One-cycle unblock notice to fetch |
| stall_err_o | output | NUM_THREADS | Unblock strobe seen for a clear flag |
| thread_state_o | output | 3*NUM_THREADS | Per-thread state code |
| stage_active_o | output | 1 | Some thread is Unblocking |

## Verification
A commit squash and a downstream stall can reach the same thread in the same cycle. In that case the block notice must vanish, and an unblock notice appears only if the thread was Blocked or Unblocking. The bench first drives thread 0 into each of the five states. It then applies every combination of squash, still-squashing, stall, redirect, leftover and skid-empty for one cycle. The resulting state, notices and activity flag are compared against an expected value that the bench derives from the priority order. Directed sequences cover sticky flags from two sources, stray unblock strobes and the isolation between threads.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int unsigned STW     = 3;
  localparam int unsigned NUM_SRC = 3;

  typedef enum logic [STW-1:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_BLK  = 3'd2,
    ST_UNB  = 3'd3,
    ST_SQ   = 3'd4
  } dsc_state_t;
endpackage

// File: rtl/dsc_stall_flags.sv
module dsc_stall_flags #(
  parameter int unsigned NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic            stalled_o,
  output logic            err_o,
  output logic [NSRC-1:0] flags_o
);
  logic [NSRC-1:0] flags_q, flags_nxt, bad;

  // a strobe raised together with a set is a legal pair; only a stray clear is an error
  always_comb begin
    flags_nxt = (flags_q | set_i) & ~clr_i;
    bad       = clr_i & ~(flags_q | set_i);
  end

  assign stalled_o = |flags_nxt;
  assign flags_o   = flags_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      err_o   <= 1'b0;
    end else begin
      flags_q <= flags_nxt;
      err_o   <= |bad;
    end
  end

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_chk
      p_flag_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!set_i[s] && !clr_i[s]) |=> $stable(flags_q[s]));
      p_stray_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_i[s] && !set_i[s] && !flags_q[s]) |=> (err_o && !flags_q[s]));
    end
  endgenerate
endmodule

// File: rtl/dsc_thread_fsm.sv
module dsc_thread_fsm
  import dsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stalled_i,
  input  logic       squash_i,
  input  logic       busy_i,
  input  logic       redirect_i,
  input  logic       leftover_i,
  input  logic       skid_empty_i,
  output dsc_state_t state_o,
  output dsc_state_t state_nxt_o,
  output logic       blk_o,
  output logic       unblk_o
);
  dsc_state_t state_q, nxt;
  logic       b, u;

  always_comb begin
    nxt = state_q;
    b   = 1'b0;
    u   = 1'b0;
    if (squash_i) begin
      nxt = ST_SQ;
      u   = (state_q == ST_BLK) || (state_q == ST_UNB);
    end else if (busy_i) begin
      nxt = ST_SQ;
    end else if (stalled_i) begin
      nxt = ST_BLK;
      b   = (state_q != ST_BLK);
    end else if (state_q == ST_BLK) begin
      nxt = ST_UNB;
    end else if (state_q == ST_SQ) begin
      nxt = ST_RUN;
    end else if (redirect_i) begin
      nxt = ST_SQ;
      u   = (state_q == ST_UNB);
    end else if (leftover_i && (state_q == ST_IDLE || state_q == ST_RUN)) begin
      nxt = ST_BLK;
      b   = 1'b1;
    end else if (state_q == ST_UNB && skid_empty_i) begin
      nxt = ST_RUN;
      u   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      blk_o   <= 1'b0;
      unblk_o <= 1'b0;
    end else begin
      state_q <= nxt;
      blk_o   <= b;
      unblk_o <= u;
    end
  end

  assign state_o     = state_q;
  assign state_nxt_o = nxt;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (state_q == ST_IDLE && !blk_o && !unblk_o));
  p_no_both_r12: assert property (@(posedge clk) disable iff (rst)
    !(blk_o && unblk_o));
  p_squash_wins_r5: assert property (@(posedge clk) disable iff (rst)
    squash_i |=> (state_q == ST_SQ && !blk_o));
  p_busy_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_i && !squash_i) |=> (state_q == ST_SQ && !blk_o && !unblk_o));
  p_block_once_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BLK && stalled_i && !squash_i && !busy_i) |=> !blk_o);
  p_drain_wait_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_UNB && !skid_empty_i && !squash_i && !busy_i && !stalled_i && !redirect_i)
      |=> (state_q == ST_UNB && !unblk_o));
endmodule

// File: rtl/dsc_activity.sv
module dsc_activity #(
  parameter int unsigned NT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NT-1:0] unb_nxt_i,
  input  logic [NT-1:0] changed_i,
  input  logic [NT-1:0] unb_cur_i,
  output logic          active_o
);
  logic active_q;

  always_ff @(posedge clk) begin
    if (rst)              active_q <= 1'b0;
    else if (|changed_i)  active_q <= |unb_nxt_i;
  end

  assign active_o = active_q;

  p_active_match_r11: assert property (@(posedge clk) disable iff (rst)
    active_q == (|unb_cur_i));
endmodule

// File: rtl/dstage_ctrl.sv
module dstage_ctrl
  import dsc_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_THREADS-1:0]     rn_blk_i,
  input  logic [NUM_THREADS-1:0]     rn_unblk_i,
  input  logic [NUM_THREADS-1:0]     ex_blk_i,
  input  logic [NUM_THREADS-1:0]     ex_unblk_i,
  input  logic [NUM_THREADS-1:0]     cm_blk_i,
  input  logic [NUM_THREADS-1:0]     cm_unblk_i,
  input  logic [NUM_THREADS-1:0]     cm_squash_i,
  input  logic [NUM_THREADS-1:0]     cm_busy_i,
  input  logic [NUM_THREADS-1:0]     skid_empty_i,
  input  logic [NUM_THREADS-1:0]     leftover_i,
  input  logic [NUM_THREADS-1:0]     redirect_i,
  output logic [NUM_THREADS-1:0]     fetch_block_o,
  output logic [NUM_THREADS-1:0]     fetch_unblock_o,
  output logic [NUM_THREADS-1:0]     stall_err_o,
  output logic [STW*NUM_THREADS-1:0] thread_state_o,
  output logic                       stage_active_o
);
  localparam int unsigned NT = NUM_THREADS;

  logic [NT-1:0] unb_nxt, unb_cur, changed;

  generate
    for (genvar t = 0; t < NT; t++) begin : g_thr
      logic [NUM_SRC-1:0] set_v, clr_v, flags;
      logic               stalled;
      dsc_state_t         st, st_nxt;

      assign set_v = {cm_blk_i[t], ex_blk_i[t], rn_blk_i[t]};
      assign clr_v = {cm_unblk_i[t], ex_unblk_i[t], rn_unblk_i[t]};

      dsc_stall_flags #(.NSRC(NUM_SRC)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .set_i     (set_v),
        .clr_i     (clr_v),
        .stalled_o (stalled),
        .err_o     (stall_err_o[t]),
        .flags_o   (flags)
      );

      dsc_thread_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .stalled_i    (stalled),
        .squash_i     (cm_squash_i[t]),
        .busy_i       (cm_busy_i[t]),
        .redirect_i   (redirect_i[t]),
        .leftover_i   (leftover_i[t]),
        .skid_empty_i (skid_empty_i[t]),
        .state_o      (st),
        .state_nxt_o  (st_nxt),
        .blk_o        (fetch_block_o[t]),
        .unblk_o      (fetch_unblock_o[t])
      );

      assign thread_state_o[STW*t +: STW] = st;
      assign unb_nxt[t] = (st_nxt == ST_UNB);
      assign unb_cur[t] = (st == ST_UNB);
      assign changed[t] = (st_nxt != st);

      p_stalled_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        ((|flags) && !cm_squash_i[t] && !cm_busy_i[t] && !(|clr_v)) |=> (st == ST_BLK));
    end
  endgenerate

  dsc_activity #(.NT(NT)) u_act (
    .clk       (clk),
    .rst       (rst),
    .unb_nxt_i (unb_nxt),
    .changed_i (changed),
    .unb_cur_i (unb_cur),
    .active_o  (stage_active_o)
  );
endmodule

// File: tb/dstage_ctrl_test.sv
`timescale 1ns/1ps
module dstage_ctrl_test;
  localparam int NT = 4;
  localparam int S_IDLE = 0, S_RUN = 1, S_BLK = 2, S_UNB = 3, S_SQ = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NT-1:0] rn_blk, rn_unblk, ex_blk, ex_unblk, cm_blk, cm_unblk;
  logic [NT-1:0] cm_squash, cm_busy, skid_empty, leftover, redirect;
  logic [NT-1:0] fblk, funblk, serr;
  logic [3*NT-1:0] tstate;
  logic active;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dstage_ctrl #(.NUM_THREADS(NT)) uut (
    .clk(clk), .rst(rst),
    .rn_blk_i(rn_blk), .rn_unblk_i(rn_unblk),
    .ex_blk_i(ex_blk), .ex_unblk_i(ex_unblk),
    .cm_blk_i(cm_blk), .cm_unblk_i(cm_unblk),
    .cm_squash_i(cm_squash), .cm_busy_i(cm_busy),
    .skid_empty_i(skid_empty), .leftover_i(leftover), .redirect_i(redirect),
    .fetch_block_o(fblk), .fetch_unblock_o(funblk), .stall_err_o(serr),
    .thread_state_o(tstate), .stage_active_o(active)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_in();
    rn_blk = '0; rn_unblk = '0; ex_blk = '0; ex_unblk = '0;
    cm_blk = '0; cm_unblk = '0; cm_squash = '0; cm_busy = '0;
    leftover = '0; redirect = '0; skid_empty = '1;
  endtask

  task automatic do_reset();
    clear_in();
    rst = 1'b1;
    cyc(); cyc();
    rst = 1'b0;
  endtask

  task automatic goto_state(int s);
    if (s == S_BLK || s == S_UNB || s == S_RUN) begin
      leftover[0] = 1'b1; cyc(); leftover[0] = 1'b0;
      chk("R9 setup", int'(tstate[2:0]), S_BLK);
    end
    if (s == S_UNB || s == S_RUN) begin
      skid_empty[0] = 1'b0; cyc();
      chk("R8 setup", int'(tstate[2:0]), S_UNB);
    end
    if (s == S_RUN) begin
      skid_empty[0] = 1'b1; cyc();
      chk("R8 setup", int'(tstate[2:0]), S_RUN);
    end
    if (s == S_SQ) begin
      cm_busy[0] = 1'b1; cyc(); cm_busy[0] = 1'b0;
      chk("R6 setup", int'(tstate[2:0]), S_SQ);
    end
  endtask

  // expected next state and notices derived from the R4 priority list
  function automatic void expect_next(input int s, input bit sq, input bit busy,
      input bit stall, input bit redir, input bit left, input bit skid,
      output int ns, output int eb, output int eu);
    ns = s; eb = 0; eu = 0;
    if (sq) begin ns = S_SQ; eu = (s == S_BLK || s == S_UNB) ? 1 : 0; end
    else if (busy) ns = S_SQ;
    else if (stall) begin ns = S_BLK; eb = (s != S_BLK) ? 1 : 0; end
    else if (s == S_BLK) ns = S_UNB;
    else if (s == S_SQ) ns = S_RUN;
    else if (redir) begin ns = S_SQ; eu = (s == S_UNB) ? 1 : 0; end
    else if (left && (s == S_IDLE || s == S_RUN)) begin ns = S_BLK; eb = 1; end
    else if (s == S_UNB && skid) begin ns = S_RUN; eu = 1; end
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_in();
    do_reset();
    // R1 reset values
    chk("R1 state", int'(tstate), 0);
    chk("R1 block", int'(fblk), 0);
    chk("R1 unblock", int'(funblk), 0);
    chk("R1 err", int'(serr), 0);
    chk("R1 active", int'(active), 0);

    // R4 R5 R6 R7 R8 R9 R10 R11 R12: sweep start state x input combination
    for (int s = 0; s < 5; s++) begin
      for (int c = 0; c < 64; c++) begin
        int ns, eb, eu;
        do_reset();
        goto_state(s);
        cm_squash[0] = c[0]; cm_busy[0] = c[1]; rn_blk[0] = c[2];
        redirect[0] = c[3]; leftover[0] = c[4]; skid_empty[0] = c[5];
        expect_next(s, c[0], c[1], c[2], c[3], c[4], c[5], ns, eb, eu);
        cyc();
        clear_in();
        chk("R4 next state", int'(tstate[2:0]), ns);
        chk(c[0] ? "R5 block notice" : "R7 block notice", int'(fblk[0]), eb);
        chk(c[0] ? "R5 unblock notice" : "R8 unblock notice", int'(funblk[0]), eu);
        chk("R11 active", int'(active), (ns == S_UNB) ? 1 : 0);
        chk("R12 both", int'(fblk[0] & funblk[0]), 0);
        chk("R13 others idle", int'(tstate[3*NT-1:3]), 0);
      end
    end

    // R2: two sticky sources, released one at a time
    do_reset();
    rn_blk[0] = 1'b1; cm_blk[0] = 1'b1; cyc(); clear_in();
    chk("R2 blocked", int'(tstate[2:0]), S_BLK);
    chk("R7 first notice", int'(fblk[0]), 1);
    cyc();
    chk("R2 sticky hold", int'(tstate[2:0]), S_BLK);
    chk("R7 no repeat", int'(fblk[0]), 0);
    rn_unblk[0] = 1'b1; cyc(); clear_in();
    chk("R2 one flag left", int'(tstate[2:0]), S_BLK);
    cm_unblk[0] = 1'b1; skid_empty[0] = 1'b0; cyc(); clear_in();
    chk("R8 unblocking", int'(tstate[2:0]), S_UNB);
    chk("R11 active high", int'(active), 1);
    chk("R3 legal unblock", int'(serr[0]), 0);
    skid_empty[0] = 1'b0; cyc();
    chk("R8 still draining", int'(tstate[2:0]), S_UNB);
    skid_empty[0] = 1'b1; cyc();
    chk("R8 drained", int'(tstate[2:0]), S_RUN);
    chk("R8 unblock notice", int'(funblk[0]), 1);
    chk("R11 active low", int'(active), 0);
    cyc();
    chk("R12 pulse ends", int'(funblk[0]), 0);

    // R3: stray unblock strobe, flag stays clear
    do_reset();
    ex_unblk[0] = 1'b1; cyc(); clear_in();
    chk("R3 err pulse", int'(serr[0]), 1);
    chk("R3 no stall", int'(tstate[2:0]), S_IDLE);
    cyc();
    chk("R3 err ends", int'(serr[0]), 0);
    chk("R3 flag clear", int'(tstate[2:0]), S_IDLE);

    // R13: thread 1 blocks while thread 0 sits idle
    do_reset();
    ex_blk[1] = 1'b1; cyc(); clear_in();
    chk("R13 thread1 blocked", int'(tstate[5:3]), S_BLK);
    chk("R13 thread0 idle", int'(tstate[2:0]), S_IDLE);
    chk("R13 notice mask", int'(fblk), 2);
    cm_squash[1] = 1'b1; rn_blk[1] = 1'b1; cyc(); clear_in();
    chk("R5 squash over stall", int'(tstate[5:3]), S_SQ);
    chk("R5 unblock mask", int'(funblk), 2);
    chk("R5 no block", int'(fblk), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule